// File: doc/BRIEF.md
# Link Self-Test Payload Checker

This block sits behind the decoder on the receive side of a serial link and judges the payload words recovered during a built-in self-test. During the test the far end sends an all-zero payload. Each recovered 35-bit word is compared against zero, and a single pass flag reports the outcome. While the test runs, the flag stays high and drops for half a word period on every word that carries a wrong bit, so external logic can count error pulses. When the test enable falls, the flag freezes on the verdict for the whole run.

The block clock runs at twice the word rate. A phase bit splits each word period into a compare phase and a report phase. A word is sampled only in the compare phase, and the error indication appears in the report phase. A saturating error-word counter is also exposed for rate measurement. The test lasts as long as the enable input stays high. Checking starts only once the receiver reports lock. If lock is lost partway through, checking pauses and resumes when lock returns.

The controller has four states:
- **IDLE**: after reset or power-down; flag low.
- **WAIT_LOCK**: test enabled, no lock; flag low.
- **CHECK**: comparing words; flag high except in an error report phase.
- **HOLD**: test ended; flag shows the verdict.

The transitions are named as follows:
- **start**: IDLE or HOLD to WAIT_LOCK when enable is high. This clears the counter and the verdict.
- **locked**: WAIT_LOCK to CHECK when lock is present.
- **unlock**: CHECK to WAIT_LOCK when lock is lost.
- **stop**: WAIT_LOCK or CHECK to HOLD when enable falls.
- **power-down**: any state to IDLE.

Top module: `lbist_rx_check`

## Requirements
- R1: After asynchronous reset (rst_n low), pass_o is 0 and err_cnt is 0.
- R2: With test_en and rx_lock both high from IDLE, pass_o rises after the second rising clock edge (start, then locked) and stays 1 while only all-zero words arrive.
- R3: A word with word_vld=1 sampled in the compare phase, with any of its 35 bits equal to 1, drives pass_o to 0 for exactly one clock cycle. That cycle is the report phase that follows. pass_o then returns to 1. The compare phase is the first clock cycle in CHECK, then every second cycle after it.
- R4: A nonzero word presented in the report phase, or presented with word_vld=0, has no effect on pass_o or err_cnt.
- R5: err_cnt increases by one for each erroring word and saturates at all ones (2^CNT_W-1).
- R6: A new test start clears err_cnt to 0 and clears the held verdict.
- R7: While rx_lock is low during a test, pass_o is 0, no word is compared, and err_cnt does not change. When lock returns, checking resumes with a compare phase.
- R8: When test_en falls after a run with no erroring word, pass_o holds 1 from the next cycle until a new start, reset or power-down.
- R9: When test_en falls after a run with one or more erroring words, pass_o holds 0. The verdict and err_cnt stay unchanged while test_en stays low.
- R10: pwr_dn high forces IDLE at the next edge, with pass_o 0 and err_cnt 0. The block stays there while pwr_dn is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the word rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_dn | input | 1 | Synchronous power-down, clears all state |
| test_en | input | 1 | Self-test enable level |
| rx_lock | input | 1 | Receiver lock indicator |
| word_vld | input | 1 | Recovered word valid strobe |
| word_data | input | DATA_W (35) | Recovered payload word |
| pass_o | output | 1 | Live error pulse during test, verdict afterwards |
| err_cnt | output | CNT_W (16) | Saturating count of erroring words |

## Verification
Suppose the phase bit drifts out of step with the state machine. Then a bad word in the compare phase does not pull the flag low in the following cycle, or a bad word in the report phase does. Either shows on pass_o within two clock cycles of the word, and the counter is off by one at the next check. A verdict bit that is set, cleared or lost at the wrong time shows one cycle after test_en falls, as the wrong held level on pass_o. A state register that ignores lock shows as a counter that moves while rx_lock is low. The flag also stays high through the lock-loss window when it should be low.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_LOCK = 2'd1,
        ST_CHECK     = 2'd2,
        ST_HOLD      = 2'd3
    } lbc_state_e;
endpackage

// File: rtl/lbc_fsm.sv
module lbc_fsm
    import lbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_dn,
    input  logic       test_en,
    input  logic       rx_lock,
    output lbc_state_e st_q,
    output logic       start_o
);
    lbc_state_e st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions: start, locked, unlock, stop, power-down
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:      if (test_en) st_d = ST_WAIT_LOCK;
            ST_WAIT_LOCK: if (!test_en) st_d = ST_HOLD;
                          else if (rx_lock) st_d = ST_CHECK;
            ST_CHECK:     if (!test_en) st_d = ST_HOLD;
                          else if (!rx_lock) st_d = ST_WAIT_LOCK;
            ST_HOLD:      if (test_en) st_d = ST_WAIT_LOCK;
            default:      st_d = ST_IDLE;
        endcase
        if (pwr_dn) st_d = ST_IDLE;
    end

    assign start_o = (st_q == ST_IDLE || st_q == ST_HOLD) && test_en && !pwr_dn;
endmodule

// File: rtl/lbc_word_cmp.sv
module lbc_word_cmp #(
    parameter int DATA_W = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              checking,
    input  logic              word_vld,
    input  logic [DATA_W-1:0] word_data,
    output logic              bad_o,
    output logic              err_ph_q
);
    logic ph_q;     // 0: compare phase, 1: report phase
    logic accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ph_q <= 1'b0;
        else if (!checking) ph_q <= 1'b0;
        else               ph_q <= ~ph_q;
    end

    assign accept = checking && !ph_q && word_vld;
    assign bad_o  = accept && (|word_data);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   err_ph_q <= 1'b0;
        else if (clr) err_ph_q <= 1'b0;
        else          err_ph_q <= bad_o;
    end
endmodule

// File: rtl/lbc_err_track.sv
module lbc_err_track #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bad,
    output logic [CNT_W-1:0] cnt_q,
    output logic             sticky_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sticky_q <= 1'b0;
        end else if (clr) begin
            cnt_q    <= '0;
            sticky_q <= 1'b0;
        end else if (bad) begin
            sticky_q <= 1'b1;
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lbist_rx_check.sv
module lbist_rx_check
    import lbc_pkg::*;
#(
    parameter int DATA_W = 35,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn,
    input  logic              test_en,
    input  logic              rx_lock,
    input  logic              word_vld,
    input  logic [DATA_W-1:0] word_data,
    output logic              pass_o,
    output logic [CNT_W-1:0]  err_cnt
);
    lbc_state_e st_q;
    logic       start;
    logic       clr;
    logic       checking;
    logic       bad;
    logic       err_ph;
    logic       sticky;

    assign clr      = start || pwr_dn;
    assign checking = (st_q == ST_CHECK) && test_en && rx_lock && !pwr_dn;

    lbc_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_dn  (pwr_dn),
        .test_en (test_en),
        .rx_lock (rx_lock),
        .st_q    (st_q),
        .start_o (start)
    );

    lbc_word_cmp #(.DATA_W(DATA_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .checking  (checking),
        .word_vld  (word_vld),
        .word_data (word_data),
        .bad_o     (bad),
        .err_ph_q  (err_ph)
    );

    lbc_err_track #(.CNT_W(CNT_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .bad      (bad),
        .cnt_q    (err_cnt),
        .sticky_q (sticky)
    );

    // output process
    always_comb begin
        pass_o = 1'b0;
        unique case (st_q)
            ST_IDLE:      pass_o = 1'b0;
            ST_WAIT_LOCK: pass_o = 1'b0;
            ST_CHECK:     pass_o = !err_ph;
            ST_HOLD:      pass_o = !sticky;
            default:      pass_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/lbist_rx_check_sva.sv
module lbist_rx_check_sva
    import lbc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_dn,
    input logic             test_en,
    input logic             rx_lock,
    input logic             pass_o,
    input logic [CNT_W-1:0] err_cnt,
    input lbc_state_e       st_q
);
    assert_err_pulse_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CHECK && !pass_o) |=> (pass_o || st_q != ST_CHECK));

    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_WAIT_LOCK || st_q == ST_CHECK) && !pwr_dn)
        |=> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + 1'b1));

    assert_nolock_no_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_WAIT_LOCK || st_q == ST_CHECK) && !rx_lock && !pwr_dn)
        |=> $stable(err_cnt));

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && !test_en && !pwr_dn) |=> ($stable(pass_o) && $stable(err_cnt)));

    assert_pwrdn_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (!pass_o && err_cnt == '0));
endmodule

bind lbist_rx_check lbist_rx_check_sva #(.CNT_W(CNT_W)) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_dn  (pwr_dn),
    .test_en (test_en),
    .rx_lock (rx_lock),
    .pass_o  (pass_o),
    .err_cnt (err_cnt),
    .st_q    (st_q)
);

// File: tb/lbist_rx_check_bench.sv
module lbist_rx_check_bench;
    localparam int DATA_W = 35;
    localparam int CNT_W  = 5;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pwr_dn = 1'b0;
    logic              test_en = 1'b0;
    logic              rx_lock = 1'b0;
    logic              word_vld = 1'b0;
    logic [DATA_W-1:0] word_data = '0;
    logic              pass_o;
    logic [CNT_W-1:0]  err_cnt;

    int vectors = 0;
    int misses  = 0;
    int exp_cnt = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    lbist_rx_check #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_lbist_rx_check (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .test_en(test_en),
        .rx_lock(rx_lock), .word_vld(word_vld), .word_data(word_data),
        .pass_o(pass_o), .err_cnt(err_cnt)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    // one word period: d0 in compare phase, d1 in report phase
    task automatic word_pair(input logic [DATA_W-1:0] d0, input logic v0,
                             input logic [DATA_W-1:0] d1, input string req);
        word_data = d0; word_vld = v0;
        step();
        if (v0 && d0 != '0 && exp_cnt < CMAX) exp_cnt++;
        chk(req, int'(pass_o), (v0 && d0 != '0) ? 0 : 1);
        word_data = d1; word_vld = 1'b1;
        step();
        chk(req, int'(pass_o), 1);
        chk(req, int'(err_cnt), exp_cnt);
        word_data = '0;
    endtask

    task automatic t_reset_R1();
        rst_n = 1'b0;
        step();
        chk("R1 pass", int'(pass_o), 0);
        chk("R1 cnt", int'(err_cnt), 0);
        rst_n = 1'b1;
        step();
        chk("R1 pass idle", int'(pass_o), 0);
    endtask

    task automatic start_test(input string req);
        test_en = 1'b1; rx_lock = 1'b1; word_vld = 1'b1; word_data = '0;
        step();
        exp_cnt = 0;
        chk(req, int'(pass_o), 0);
        chk(req, int'(err_cnt), 0);
        step();
        chk(req, int'(pass_o), 1);
    endtask

    task automatic t_clean_run_R2_R8();
        start_test("R2 start");
        for (int i = 0; i < 6; i++) word_pair('0, 1'b1, '0, "R2 clean words");
        test_en = 1'b0;
        step();
        chk("R8 hold high", int'(pass_o), 1);
        for (int i = 0; i < 5; i++) step();
        chk("R8 hold high later", int'(pass_o), 1);
        chk("R8 cnt", int'(err_cnt), 0);
    endtask

    task automatic t_errors_R3_R4_R9();
        start_test("R6 restart");
        word_pair(35'h1, 1'b1, '0, "R3 bit0");
        word_pair(35'h4_0000_0000, 1'b1, '0, "R3 bit34");
        word_pair('0, 1'b1, 35'h7_FFFF_FFFF, "R4 report phase ignored");
        word_pair(35'h0_0002_0000, 1'b0, '0, "R4 invalid ignored");
        word_pair('1, 1'b1, '0, "R3 all ones");
        word_pair('0, 1'b1, '0, "R3 clean after");
        chk("R5 count", int'(err_cnt), 3);
        test_en = 1'b0;
        step();
        chk("R9 hold low", int'(pass_o), 0);
        word_data = '1; word_vld = 1'b1; rx_lock = 1'b0;
        for (int i = 0; i < 6; i++) step();
        chk("R9 held low", int'(pass_o), 0);
        chk("R9 cnt held", int'(err_cnt), 3);
        rx_lock = 1'b1; word_data = '0;
    endtask

    task automatic t_restart_R6();
        test_en = 1'b1;
        step();
        chk("R6 cnt cleared", int'(err_cnt), 0);
        chk("R6 waiting", int'(pass_o), 0);
        exp_cnt = 0;
        step();
        chk("R6 verdict cleared", int'(pass_o), 1);
    endtask

    task automatic t_lock_loss_R7();
        word_pair(35'h8, 1'b1, '0, "R7 pre");
        rx_lock = 1'b0; word_data = 35'h1F; word_vld = 1'b1;
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R7 unlocked pass", int'(pass_o), 0);
            chk("R7 unlocked cnt", int'(err_cnt), exp_cnt);
        end
        rx_lock = 1'b1; word_data = '0;
        step();
        chk("R7 relock", int'(pass_o), 1);
        word_pair(35'h100, 1'b1, '0, "R7 resumed");
        chk("R7 count", int'(err_cnt), 2);
    endtask

    task automatic t_saturate_R5();
        for (int i = 0; i < CMAX + 6; i++) word_pair(35'h2, 1'b1, '0, "R5 saturate");
        chk("R5 at max", int'(err_cnt), CMAX);
    endtask

    task automatic t_pwrdn_R10();
        test_en = 1'b0;
        step();
        chk("R9 hold low sat", int'(pass_o), 0);
        pwr_dn = 1'b1;
        step();
        chk("R10 pass", int'(pass_o), 0);
        chk("R10 cnt", int'(err_cnt), 0);
        test_en = 1'b1;
        for (int i = 0; i < 3; i++) step();
        chk("R10 stays idle", int'(pass_o), 0);
        pwr_dn = 1'b0; test_en = 1'b0;
        step();
        chk("R10 idle after", int'(pass_o), 0);
    endtask

    task automatic t_reset_in_hold_R1();
        start_test("R2 second start");
        word_pair(35'h40, 1'b1, '0, "R3 single");
        test_en = 1'b0;
        step();
        chk("R9 low before reset", int'(pass_o), 0);
        rst_n = 1'b0;
        #1;
        chk("R1 reset clears verdict", int'(pass_o), 0);
        chk("R1 reset clears cnt", int'(err_cnt), 0);
        step();
        rst_n = 1'b1;
    endtask

    initial begin
        step();
        t_reset_R1();
        t_clean_run_R2_R8();
        t_errors_R3_R4_R9();
        t_restart_R6();
        t_lock_loss_R7();
        t_saturate_R5();
        t_pwrdn_R10();
        t_reset_in_hold_R1();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule